// File: doc/BRIEF.md
# Sign-Injection and Raw-Move Unit

This unit handles the single-precision operations that change only sign bits or move raw bit patterns. It has three sign-injection forms: copy the sign of the second operand, copy its inverted sign, and xor the two signs. It also has two raw moves between the float and integer register files. No arithmetic is performed, nothing is rounded, and the exception flags are never touched.

Each operation is accepted on a cycle where `in_valid` is high. The result appears one clock later, together with a write enable for either the float file or the integer file. Only bits 31:0 of the float operands take part. A result written to the float file is NaN-boxed when the float register is wider than 32 bits: every bit above bit 31 is set to one. A 32-bit pattern moved to the integer file is sign-extended to the integer width. Operation codes: 0 sign copy, 1 inverted sign copy, 2 sign xor, 3 float-to-integer move, 4 integer-to-float move. Codes 5 to 7 are reserved.

Top module: `sgnmv_unit`

## Requirements
- R1: After reset, `out_valid`, `wr_float` and `wr_int` are 0, and `f_res` and `x_res` are all zeros.
- R2: Op 0 accepted in cycle n gives, in cycle n+1, `f_res[31]` = `src_b[31]` and `f_res[30:0]` = `src_a[30:0]`, with `wr_float`=1 and `wr_int`=0.
- R3: Op 1 gives `f_res[31]` = NOT `src_b[31]` and `f_res[30:0]` = `src_a[30:0]`. When both operands are equal, the result is the operand with its sign flipped.
- R4: Op 2 gives `f_res[31]` = `src_a[31]` XOR `src_b[31]` and `f_res[30:0]` = `src_a[30:0]`. When both operands are equal, the result has its sign bit cleared.
- R5: Op 3 gives `x_res` = `src_a[31:0]` sign-extended from bit 31 to XLEN bits, with `wr_int`=1 and `wr_float`=0. `f_res` keeps its previous value.
- R6: Op 4 gives `f_res[31:0]` = `src_x[31:0]`, with `wr_float`=1 and `wr_int`=0. `x_res` keeps its previous value.
- R7: Whenever `wr_float` is 1 and FLEN > 32, `f_res[FLEN-1:32]` is all ones.
- R8: Bits of `src_a` and `src_b` above bit 31, and bits of `src_x` above bit 31, have no effect on any result.
- R9: NaN operands are passed through bit-exact. Payload and quiet bit in `f_res[30:0]` equal `src_a[30:0]`, with no canonical NaN substituted.
- R10: `out_valid` in cycle n+1 equals `in_valid` in cycle n. When `in_valid` is 0, both write enables are 0 in the next cycle, and `f_res` and `x_res` keep their values.
- R11: A reserved op (5, 6 or 7) with `in_valid`=1 gives `out_valid`=1, `wr_float`=0 and `wr_int`=0, and both result ports keep their values. At no time are both write enables 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0..4, 5..7 reserved) |
| src_a | input | FLEN | First float operand register |
| src_b | input | FLEN | Second float operand register |
| src_x | input | XLEN | Integer operand register |
| out_valid | output | 1 | Registered copy of in_valid |
| wr_float | output | 1 | Result targets the float file |
| wr_int | output | 1 | Result targets the integer file |
| f_res | output | FLEN | Float-file result, NaN-boxed |
| x_res | output | XLEN | Integer-file result, sign-extended |

## Verification
The properties assume that `in_valid` and `op` are known and are stable around the sampling edge. They do not assume that operands are NaN-boxed or that the op code is legal. The bench drives all inputs on the falling edge, so every registered value is settled before it is compared. Operands include quiet and signalling NaNs, infinities, signed zeros and random patterns with junk in the upper bits. Reserved codes and idle cycles are interleaved with real operations, so that every hold rule is exercised.

// File: rtl/sgnmv_pkg.sv
package sgnmv_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SGN_COPY = 3'd0,
        OP_SGN_FLIP = 3'd1,
        OP_SGN_XOR  = 3'd2,
        OP_MV_F2X   = 3'd3,
        OP_MV_X2F   = 3'd4
    } sgnmv_op_e;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SIGN_B = WORD_W - 1;

endpackage

// File: rtl/sgnmv_inject.sv
module sgnmv_inject
    import sgnmv_pkg::*;
(
    input  logic [OP_W-1:0]   mode,
    input  logic [WORD_W-1:0] mag_src,
    input  logic [WORD_W-1:0] sgn_src,
    output logic [WORD_W-1:0] word_out
);

    logic new_sign;

    always_comb begin
        unique case (mode)
            OP_SGN_COPY: new_sign = sgn_src[SIGN_B];
            OP_SGN_FLIP: new_sign = ~sgn_src[SIGN_B];
            OP_SGN_XOR:  new_sign = mag_src[SIGN_B] ^ sgn_src[SIGN_B];
            default:     new_sign = mag_src[SIGN_B];
        endcase
        word_out = {new_sign, mag_src[SIGN_B-1:0]};
    end

endmodule

// File: rtl/sgnmv_box.sv
module sgnmv_box
    import sgnmv_pkg::*;
#(
    parameter int unsigned FLEN = 64
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [FLEN-1:0]   boxed
);

    localparam int unsigned PAD_W = FLEN - WORD_W;

    generate
        if (PAD_W > 0) begin : g_box
            assign boxed = {{PAD_W{1'b1}}, word_in};
        end else begin : g_flat
            assign boxed = word_in;
        end
    endgenerate

endmodule

// File: rtl/sgnmv_sext.sv
module sgnmv_sext
    import sgnmv_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [XLEN-1:0]   wide
);

    localparam int unsigned EXT_W = XLEN - WORD_W;

    generate
        if (EXT_W > 0) begin : g_ext
            assign wide = {{EXT_W{word_in[SIGN_B]}}, word_in};
        end else begin : g_flat
            assign wide = word_in;
        end
    endgenerate

endmodule

// File: rtl/sgnmv_unit.sv
module sgnmv_unit
    import sgnmv_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned FLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [FLEN-1:0]     src_a,
    input  logic [FLEN-1:0]     src_b,
    input  logic [XLEN-1:0]     src_x,
    output logic                out_valid,
    output logic                wr_float,
    output logic                wr_int,
    output logic [FLEN-1:0]     f_res,
    output logic [XLEN-1:0]     x_res
);

    typedef struct packed {
        logic            vld;
        logic            wf;
        logic            wx;
        logic [FLEN-1:0] f;
        logic [XLEN-1:0] x;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0] inj_word_d;
    logic [WORD_W-1:0] fword_d;
    logic [FLEN-1:0]   fboxed_d;
    logic [XLEN-1:0]   xwide_d;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^{src_a, src_b, src_x};

    sgnmv_inject u_inject (
        .mode     (op),
        .mag_src  (src_a[WORD_W-1:0]),
        .sgn_src  (src_b[WORD_W-1:0]),
        .word_out (inj_word_d)
    );

    assign fword_d = (op == OP_MV_X2F) ? src_x[WORD_W-1:0] : inj_word_d;

    sgnmv_box #(.FLEN(FLEN)) u_box (
        .word_in (fword_d),
        .boxed   (fboxed_d)
    );

    sgnmv_sext #(.XLEN(XLEN)) u_sext (
        .word_in (src_a[WORD_W-1:0]),
        .wide    (xwide_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wf  = 1'b0;
        st_d.wx  = 1'b0;
        if (in_valid) begin
            unique case (op)
                OP_SGN_COPY, OP_SGN_FLIP, OP_SGN_XOR, OP_MV_X2F: begin
                    st_d.wf = 1'b1;
                    st_d.f  = fboxed_d;
                end
                OP_MV_F2X: begin
                    st_d.wx = 1'b1;
                    st_d.x  = xwide_d;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign wr_float  = st_q.wf;
    assign wr_int    = st_q.wx;
    assign f_res     = st_q.f;
    assign x_res     = st_q.x;

endmodule

// File: rtl/sgnmv_unit_chk.sv
module sgnmv_unit_chk
    import sgnmv_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned FLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [31:0]       a_lo,
    input logic [31:0]       b_lo,
    input logic [31:0]       x_lo,
    input logic              out_valid,
    input logic              wr_float,
    input logic              wr_int,
    input logic [FLEN-1:0]   f_res,
    input logic [XLEN-1:0]   x_res
);

    localparam logic [FLEN-1:0] UPPER = ~FLEN'(32'hFFFF_FFFF);

    p_vld_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_float && !wr_int && $stable(f_res) && $stable(x_res)));
    p_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0) |=> (wr_float && f_res[31:0] == {$past(b_lo[31]), $past(a_lo[30:0])}));
    p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1) |=> (f_res[31] != $past(b_lo[31]) && f_res[30:0] == $past(a_lo[30:0])));
    p_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2) |=> (f_res[31] == ($past(a_lo[31]) ^ $past(b_lo[31]))));
    p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_int |-> (x_res == XLEN'($signed(x_res[31:0]))));
    p_mvx2f_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4) |=> (wr_float && f_res[31:0] == $past(x_lo)));
    p_box_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_float |-> ((f_res & UPPER) == UPPER));
    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_float, wr_int}));
    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 3'd4) |=> (out_valid && !wr_float && !wr_int && $stable(f_res) && $stable(x_res)));

endmodule

bind sgnmv_unit sgnmv_unit_chk #(.XLEN(XLEN), .FLEN(FLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a_lo      (src_a[31:0]),
    .b_lo      (src_b[31:0]),
    .x_lo      (src_x[31:0]),
    .out_valid (out_valid),
    .wr_float  (wr_float),
    .wr_int    (wr_int),
    .f_res     (f_res),
    .x_res     (x_res)
);

// File: tb/tb_sgnmv_unit.sv
module tb_sgnmv_unit;

    localparam int XLEN = 64;
    localparam int FLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [2:0]      op = 3'd0;
    logic [FLEN-1:0] src_a = '0;
    logic [FLEN-1:0] src_b = '0;
    logic [XLEN-1:0] src_x = '0;
    logic            out_valid, wr_float, wr_int;
    logic [FLEN-1:0] f_res;
    logic [XLEN-1:0] x_res;

    int checks = 0;
    int errors = 0;

    logic [FLEN-1:0] m_f = '0;
    logic [XLEN-1:0] m_x = '0;
    logic            m_wf, m_wx;

    always #4 clk = ~clk;

    sgnmv_unit #(.XLEN(XLEN), .FLEN(FLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .src_x(src_x),
        .out_valid(out_valid), .wr_float(wr_float), .wr_int(wr_int),
        .f_res(f_res), .x_res(x_res)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model from the requirements
    task automatic model(input logic v, input logic [2:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] x);
        logic [31:0] w;
        m_wf = 1'b0; m_wx = 1'b0;
        if (v) begin
            case (o)
                3'd0: begin w = {b[31], a[30:0]};         m_wf = 1'b1; end
                3'd1: begin w = {~b[31], a[30:0]};        m_wf = 1'b1; end
                3'd2: begin w = {a[31] ^ b[31], a[30:0]}; m_wf = 1'b1; end
                3'd4: begin w = x[31:0];                  m_wf = 1'b1; end
                default: w = 32'h0;
            endcase
            if (m_wf) m_f = {32'hFFFF_FFFF, w};
            if (o == 3'd3) begin
                m_x = {{32{a[31]}}, a[31:0]};
                m_wx = 1'b1;
            end
        end
    endtask

    // called at a falling edge; checks at the next falling edge
    task automatic issue(input string tag, input logic v, input logic [2:0] o,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] x);
        in_valid = v; op = o; src_a = a; src_b = b; src_x = x;
        model(v, o, a, b, x);
        @(negedge clk);
        chk({tag, " valid"}, 64'(out_valid), 64'(v));
        chk({tag, " wr_float"}, 64'(wr_float), 64'(m_wf));
        chk({tag, " wr_int"}, 64'(wr_int), 64'(m_wx));
        chk({tag, " f_res"}, f_res, m_f);
        chk({tag, " x_res"}, x_res, m_x);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 wr_float", 64'(wr_float), 64'd0);
        chk("R1 wr_int", 64'(wr_int), 64'd0);
        chk("R1 f_res", f_res, 64'd0);
        chk("R1 x_res", x_res, 64'd0);
    endtask

    task automatic t_copy;
        issue("R2 copy pos<-neg", 1, 3'd0, 64'h0000_0000_3F80_0000, 64'h0000_0000_C000_0000, 0);
        issue("R2 copy neg<-pos", 1, 3'd0, 64'h0000_0000_BF80_0000, 64'h0000_0000_4000_0000, 0);
        issue("R7 copy boxed +0", 1, 3'd0, 64'h0, 64'h0, 0);
    endtask

    task automatic t_flip;
        issue("R3 flip", 1, 3'd1, 64'hFFFF_FFFF_4049_0FDB, 64'hFFFF_FFFF_0000_0001, 0);
        issue("R3 negate same reg", 1, 3'd1, 64'hFFFF_FFFF_C120_0000, 64'hFFFF_FFFF_C120_0000, 0);
        issue("R3 negate -0", 1, 3'd1, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000, 0);
    endtask

    task automatic t_xor;
        issue("R4 xor", 1, 3'd2, 64'hFFFF_FFFF_C0A0_0000, 64'hFFFF_FFFF_4000_0000, 0);
        issue("R4 abs same reg", 1, 3'd2, 64'hFFFF_FFFF_FF80_0000, 64'hFFFF_FFFF_FF80_0000, 0);
        issue("R4 xor both neg", 1, 3'd2, 64'hFFFF_FFFF_8123_4567, 64'hFFFF_FFFF_8000_0000, 0);
    endtask

    task automatic t_f2x;
        issue("R5 f2x negative", 1, 3'd3, 64'hFFFF_FFFF_BF80_0000, 0, 0);
        issue("R5 f2x positive", 1, 3'd3, 64'hDEAD_BEEF_7F7F_FFFF, 0, 0);
    endtask

    task automatic t_x2f;
        issue("R6 x2f", 1, 3'd4, 0, 0, 64'h1234_5678_8765_4321);
        issue("R6 x2f pattern", 1, 3'd4, 0, 0, 64'h0000_0000_7FC0_0000);
    endtask

    task automatic t_upper;
        issue("R8 junk upper a/b", 1, 3'd0, 64'h0123_4567_4040_0000, 64'h89AB_CDEF_8000_0000, 0);
        issue("R8 zero upper a/b", 1, 3'd0, 64'h0000_0000_4040_0000, 64'h0000_0000_8000_0000, 0);
        issue("R8 junk upper x", 1, 3'd4, 0, 0, 64'hAAAA_5555_0000_0042);
    endtask

    task automatic t_nan;
        issue("R9 sNaN payload", 1, 3'd1, 64'hFFFF_FFFF_7F80_0001, 64'h0, 0);
        issue("R9 qNaN payload", 1, 3'd2, 64'hFFFF_FFFF_FFC1_2345, 64'hFFFF_FFFF_8000_0000, 0);
        issue("R9 neg qNaN copy", 1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0);
    endtask

    task automatic t_idle;
        issue("R10 idle", 0, 3'd0, 64'h1111_1111_2222_2222, 64'h3333, 64'h4444);
        issue("R10 idle f2x", 0, 3'd3, 64'hFFFF_FFFF_8000_0000, 0, 0);
    endtask

    task automatic t_reserved;
        for (int o = 5; o < 8; o++)
            issue("R11 reserved", 1, 3'(o), 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 64'h77);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b, x;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            x = {$urandom(), $urandom()};
            issue("R2-R11 random", ($urandom() % 8) != 0, 3'($urandom() % 8), a, b, x);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_copy();
        t_flip();
        t_xor();
        t_f2x();
        t_x2f();
        t_upper();
        t_nan();
        t_idle();
        t_reserved();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule